// File: doc/BRIEF.md
# Access-Order Arithmetic Coprocessor

This block is a math helper that sits on the 8-bit register bus of a small processor. Software loads operands one byte at a time into two operand ports, A and B. The order of those writes tells the block which operation to run, so software never writes an opcode. The block supports five operations: a 32-by-16 unsigned divide, a 16-by-16 unsigned divide, a 16x16 multiply, a 32-bit logical shift in either direction, and a 32-bit normalize. Results come back one byte at a time from the same ports, most significant byte first. A third data port gives the normalize exponent.

Each operation stays busy for a fixed number of cycles. During that time the status register shows busy, and result reads return zero. An access to A, B or the exponent port that fits no legal order puts the block into a locked error state. The lock holds until software writes the restart bit. Accesses to any other address may be placed anywhere inside a sequence and do not disturb it.

Top module: `seqmath_top`

## Requirements
- R1: The address map is A=0, B=1, X (exponent)=2, CFG=3, STAT=4. Addresses 5 to 7 are unused. After reset, STAT, CFG and unused addresses read 0x00. Read data is combinational and is valid in the cycle of the read strobe. It is 0x00 when no read strobe is asserted.
- R2: Four writes to A, least significant byte first, followed by two writes to B (divisor, LSB first), start a 32/16 divide. After completion, four reads of A return the 32-bit quotient MSB first. Two reads of B return the 16-bit remainder MSB first.
- R3: Two writes to A followed by two writes to B start a 16/16 divide. Reads of A return the 16-bit quotient in two bytes, MSB first, and 0x00 after that. B returns the remainder.
- R4: Two writes to B followed by two writes to A start a multiply. Four reads of A return the 32-bit product MSB first.
- R5: Four writes to A followed by a CFG write with bit 7 (go) set start a shift when CFG bit 6 is 0. CFG bits 4:0 give the count. CFG bit 5 selects the direction: 1 is logical right, 0 is left. Four reads of A return the result MSB first. CFG reads back bits 6:0 with bit 7 read as 0.
- R6: The same sequence with CFG bit 6 set starts a normalize. A returns the input shifted left until bit 31 is 1. X bits 4:0 return the shift count. An input of zero returns a mantissa of 0 and an exponent of 31, and sets STAT bit 3 (zero).
- R7: STAT bit 0 (busy) rises in the cycle after the completing access. It stays high for exactly 36 cycles for the 32/16 divide, shift and normalize, and for 24 cycles for the 16/16 divide and the multiply. STAT bit 4 (done) is high from then until the next sequence starts.
- R8: Reads of A, B or X while busy return 0x00 and consume no result byte.
- R9: A zero divisor still completes in the normal time. The quotient is all ones at the width of the operation, the remainder is the low 16 bits of the dividend, and STAT bit 2 (overflow) is set. The next start clears it.
- R10: Accesses to CFG (without go), STAT (without restart) or unused addresses, placed inside a sequence, do not change its outcome.
- R11: An out-of-order access to A, B or X sets STAT bit 1 (error) and aborts any running operation. Out-of-order accesses include: a read of A, B or X outside done or busy, any write to X, a go with no four-byte A load, and a write while busy. While error is set, data accesses are ignored and read 0x00, and go has no effect.
- R12: Writing STAT with bit 0 set returns the block to idle at any time. It clears busy, error, done, overflow and zero.
- R13: While done, writes to A or B begin a new sequence without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |

## Verification
The bench carries its own model of the access rules and the arithmetic. It predicts the result of every bus cycle. Read data is combinational, so the bench samples it in the same cycle as the strobe, one nanosecond after the falling edge. Completing writes take effect at the next rising edge. From the cycle after that edge, the bench polls STAT every cycle. It expects busy for exactly 24 or 36 polls and done on the poll that follows. Result, error and flag reads are then compared byte by byte against the model's values.

// File: rtl/seqmath_pkg.sv
package seqmath_pkg;

  typedef enum logic [2:0] {
    OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT, OP_NORM
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_RUN, S_DONE, S_ERR
  } seq_st_e;

  typedef struct packed {
    logic [31:0] hi;
    logic [15:0] lo;
    logic [4:0]  expo;
    logic        ovf;
    logic        zro;
  } result_t;

  function automatic logic [4:0] lead_zeros(input logic [31:0] v);
    logic [4:0] z;
    logic       hit;
    z   = 5'd0;
    hit = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      z   = z + 5'd1;
      end
    end
    return z;
  endfunction

  function automatic result_t run_op(input op_e op, input logic [31:0] a,
                                     input logic [15:0] b, input logic [4:0] n,
                                     input logic right);
    result_t r;
    r = '0;
    case (op)
      OP_DIV32: begin
        if (b == 16'h0) begin
          r.hi  = '1;
          r.lo  = a[15:0];
          r.ovf = 1'b1;
        end else begin
          r.hi = a / {16'h0, b};
          r.lo = 16'(a % {16'h0, b});
        end
      end
      OP_DIV16: begin
        if (b == 16'h0) begin
          r.hi  = {16'hFFFF, 16'h0};
          r.lo  = a[15:0];
          r.ovf = 1'b1;
        end else begin
          r.hi = {a[15:0] / b, 16'h0};
          r.lo = a[15:0] % b;
        end
      end
      OP_MUL:   r.hi = {16'h0, a[15:0]} * {16'h0, b};
      OP_SHIFT: r.hi = right ? (a >> n) : (a << n);
      OP_NORM: begin
        if (a == 32'h0) begin
          r.expo = 5'd31;
          r.zro  = 1'b1;
        end else begin
          r.expo = lead_zeros(a);
          r.hi   = a << r.expo;
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seqmath_seq.sv
module seqmath_seq
  import seqmath_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic        wr_x,
  input  logic        rd_dat,
  input  logic        go_wr,
  input  logic        norm_sel,
  input  logic        restart,
  input  logic        fin,
  input  logic [7:0]  wdata,
  output logic        start,
  output op_e         op,
  output logic [31:0] opa_nx,
  output logic [15:0] opb_nx,
  output logic        err_evt,
  output seq_st_e     st
);

  seq_st_e     st_nx;
  logic [2:0]  na, na_nx, nb, nb_nx;
  logic        first_b, first_b_nx;
  logic [31:0] opa;
  logic [15:0] opb;
  logic        bad;

  always_comb begin
    st_nx      = st;
    na_nx      = na;
    nb_nx      = nb;
    first_b_nx = first_b;
    opa_nx     = opa;
    opb_nx     = opb;
    start      = 1'b0;
    op         = OP_DIV32;
    bad        = 1'b0;
    case (st)
      S_IDLE, S_DONE: begin
        if (wr_a) begin
          st_nx = S_LOAD; first_b_nx = 1'b0; na_nx = 3'd1; nb_nx = 3'd0;
          opa_nx = {24'h0, wdata}; opb_nx = 16'h0;
        end else if (wr_b) begin
          st_nx = S_LOAD; first_b_nx = 1'b1; na_nx = 3'd0; nb_nx = 3'd1;
          opb_nx = {8'h0, wdata}; opa_nx = 32'h0;
        end else if (wr_x || go_wr || (rd_dat && st == S_IDLE)) begin
          bad = 1'b1;
        end
      end
      S_LOAD: begin
        if (!first_b) begin
          if (wr_a) begin
            if (nb == 3'd0 && na < 3'd4) begin
              opa_nx[{na[1:0], 3'b000} +: 8] = wdata;
              na_nx = na + 3'd1;
            end else bad = 1'b1;
          end else if (wr_b) begin
            if (na == 3'd2 || na == 3'd4) begin
              opb_nx[{nb[0], 3'b000} +: 8] = wdata;
              nb_nx = nb + 3'd1;
              if (nb == 3'd1) begin
                start = 1'b1;
                op    = (na == 3'd4) ? OP_DIV32 : OP_DIV16;
                st_nx = S_RUN;
              end
            end else bad = 1'b1;
          end else if (go_wr) begin
            if (na == 3'd4 && nb == 3'd0) begin
              start = 1'b1;
              op    = norm_sel ? OP_NORM : OP_SHIFT;
              st_nx = S_RUN;
            end else bad = 1'b1;
          end else if (wr_x || rd_dat) bad = 1'b1;
        end else begin
          if (wr_b) begin
            if (nb == 3'd1 && na == 3'd0) begin
              opb_nx[15:8] = wdata;
              nb_nx = 3'd2;
            end else bad = 1'b1;
          end else if (wr_a) begin
            if (nb == 3'd2) begin
              opa_nx[{na[0], 3'b000} +: 8] = wdata;
              na_nx = na + 3'd1;
              if (na == 3'd1) begin
                start = 1'b1;
                op    = OP_MUL;
                st_nx = S_RUN;
              end
            end else bad = 1'b1;
          end else if (go_wr || wr_x || rd_dat) bad = 1'b1;
        end
      end
      S_RUN: begin
        if (wr_a || wr_b || wr_x || go_wr) bad = 1'b1;
        else if (fin) st_nx = S_DONE;
      end
      default: ;
    endcase
    if (bad) begin
      st_nx = S_ERR;
      start = 1'b0;
    end
    if (restart) begin
      st_nx = S_IDLE;
      start = 1'b0;
    end
  end

  assign err_evt = bad && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      na      <= 3'd0;
      nb      <= 3'd0;
      first_b <= 1'b0;
      opa     <= 32'h0;
      opb     <= 16'h0;
    end else begin
      st      <= st_nx;
      na      <= na_nx;
      nb      <= nb_nx;
      first_b <= first_b_nx;
      opa     <= opa_nx;
      opb     <= opb_nx;
    end
  end

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR && !restart) |=> (st == S_ERR));

  // R13
  done_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && (wr_a || wr_b) && !restart) |=> (st == S_LOAD));

endmodule

// File: rtl/seqmath_exec.sv
module seqmath_exec
  import seqmath_pkg::*;
#(
  parameter int LONG_CYC  = 36,
  parameter int SHORT_CYC = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  op_e         op,
  input  logic [31:0] opa,
  input  logic [15:0] opb,
  input  logic [4:0]  sh_cnt,
  input  logic        sh_right,
  input  logic        abort,
  input  logic        clear,
  input  logic        pop_a,
  input  logic        pop_b,
  output logic        busy,
  output logic        fin,
  output result_t     res
);

  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             short_op;

  assign short_op = (op == OP_DIV16) || (op == OP_MUL);
  assign fin      = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      res  <= '0;
    end else if (clear) begin
      busy <= 1'b0;
      cnt  <= '0;
      res  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      res  <= run_op(op, opa, opb, sh_cnt, sh_right);
      busy <= 1'b1;
      cnt  <= short_op ? CNT_W'(SHORT_CYC) : CNT_W'(LONG_CYC);
    end else begin
      if (busy) begin
        if (cnt == CNT_W'(1)) busy <= 1'b0;
        cnt <= cnt - CNT_W'(1);
      end
      if (pop_a) res.hi <= {res.hi[23:0], 8'h00};
      if (pop_b) res.lo <= {res.lo[7:0], 8'h00};
    end
  end

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !clear) |=> busy);

  // R6
  norm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !clear && op == OP_NORM && opa == 32'h0)
      |=> (res.zro && res.expo == 5'd31 && res.hi == 32'h0));

endmodule

// File: rtl/seqmath_top.sv
module seqmath_top
  import seqmath_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int A_ADDR    = 0,
  parameter int B_ADDR    = 1,
  parameter int X_ADDR    = 2,
  parameter int CFG_ADDR  = 3,
  parameter int STAT_ADDR = 4,
  parameter int LONG_CYC  = 36,
  parameter int SHORT_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  logic    sel_a, sel_b, sel_x, sel_cfg, sel_st;
  logic    wr_a, wr_b, wr_x, rd_dat, go_wr, restart;
  logic    pop_a, pop_b;
  logic [6:0] cfg, cfg_nx;
  logic    start, err_evt, busy, fin;
  op_e     op;
  logic [31:0] opa_nx;
  logic [15:0] opb_nx;
  seq_st_e st;
  result_t res;
  logic    in_done, in_err;

  assign sel_a   = bus_addr == ADDR_W'(A_ADDR);
  assign sel_b   = bus_addr == ADDR_W'(B_ADDR);
  assign sel_x   = bus_addr == ADDR_W'(X_ADDR);
  assign sel_cfg = bus_addr == ADDR_W'(CFG_ADDR);
  assign sel_st  = bus_addr == ADDR_W'(STAT_ADDR);

  assign wr_a    = bus_wr && sel_a;
  assign wr_b    = bus_wr && sel_b;
  assign wr_x    = bus_wr && sel_x;
  assign rd_dat  = bus_rd && !bus_wr && (sel_a || sel_b || sel_x);
  assign go_wr   = bus_wr && sel_cfg && bus_wdata[7];
  assign restart = bus_wr && sel_st && bus_wdata[0];
  assign cfg_nx  = (bus_wr && sel_cfg) ? bus_wdata[6:0] : cfg;

  assign in_done = st == S_DONE;
  assign in_err  = st == S_ERR;
  assign pop_a   = bus_rd && !bus_wr && sel_a && in_done;
  assign pop_b   = bus_rd && !bus_wr && sel_b && in_done;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= 7'h0;
    else        cfg <= cfg_nx;
  end

  seqmath_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .wr_x    (wr_x),
    .rd_dat  (rd_dat),
    .go_wr   (go_wr),
    .norm_sel(cfg_nx[6]),
    .restart (restart),
    .fin     (fin),
    .wdata   (bus_wdata),
    .start   (start),
    .op      (op),
    .opa_nx  (opa_nx),
    .opb_nx  (opb_nx),
    .err_evt (err_evt),
    .st      (st)
  );

  seqmath_exec #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC)
  ) i_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .opa     (opa_nx),
    .opb     (opb_nx),
    .sh_cnt  (cfg_nx[4:0]),
    .sh_right(cfg_nx[5]),
    .abort   (err_evt || restart),
    .clear   (restart),
    .pop_a   (pop_a),
    .pop_b   (pop_b),
    .busy    (busy),
    .fin     (fin),
    .res     (res)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      if (sel_a)        bus_rdata = in_done ? res.hi[31:24] : 8'h00;
      else if (sel_b)   bus_rdata = in_done ? res.lo[15:8] : 8'h00;
      else if (sel_x)   bus_rdata = in_done ? {3'b000, res.expo} : 8'h00;
      else if (sel_cfg) bus_rdata = {1'b0, cfg};
      else if (sel_st)  bus_rdata = {3'b000, in_done, res.zro, res.ovf, in_err, busy};
    end
  end

  // R8
  busy_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd && (sel_a || sel_b || sel_x)) |-> (bus_rdata == 8'h00));

  // R11
  busy_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_RUN));

  // R12
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!busy && st == S_IDLE));

  // R7
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !err_evt && !restart) |=> (in_done && !busy));

endmodule

// File: tb/test_seqmath_top.sv
`timescale 1ns/100ps
module test_seqmath_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd7;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  wire  [7:0] rdata;

  always #2.5 clk = ~clk;

  seqmath_top i_seqmath_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  localparam int M_IDLE = 0, M_LOAD = 1, M_RUN = 2, M_DONE = 3, M_ERR = 4;

  int nchk = 0, nfail = 0, cyc = 0;
  int ms = M_IDLE, na = 0, nb = 0, left = 0, mexp = 0;
  bit fb = 0, movf = 0, mzro = 0;
  logic [6:0] mcfg = 7'h0;
  longint unsigned va = 0, vb = 0;
  logic [7:0] qa[$], qb[$];

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push32(input longint unsigned v, ref logic [7:0] q[$]);
    for (int i = 3; i >= 0; i--) q.push_back(8'((v >> (8 * i)) & 64'hFF));
  endtask

  task automatic begin_op(input int kind);
    longint unsigned a, b, q, r;
    int k;
    qa.delete(); qb.delete();
    movf = 0; mzro = 0; mexp = 0;
    a = va & 64'hFFFF_FFFF; b = vb & 64'hFFFF;
    case (kind)
      0: begin
        if (b == 0) begin q = 64'hFFFF_FFFF; r = a & 64'hFFFF; movf = 1; end
        else begin q = a / b; r = a % b; end
        push32(q, qa);
        qb.push_back(8'(r >> 8)); qb.push_back(8'(r & 64'hFF));
      end
      1: begin
        a = a & 64'hFFFF;
        if (b == 0) begin q = 64'hFFFF; r = a; movf = 1; end
        else begin q = a / b; r = a % b; end
        qa.push_back(8'(q >> 8)); qa.push_back(8'(q & 64'hFF));
        qb.push_back(8'(r >> 8)); qb.push_back(8'(r & 64'hFF));
      end
      2: push32((a & 64'hFFFF) * b, qa);
      3: push32(mcfg[5] ? (a >> mcfg[4:0]) : ((a << mcfg[4:0]) & 64'hFFFF_FFFF), qa);
      default: begin
        if (a == 0) begin mexp = 31; mzro = 1; end
        else begin
          k = 0;
          while ((a & 64'h8000_0000) == 0) begin a = (a << 1) & 64'hFFFF_FFFF; k++; end
          mexp = k;
          push32(a, qa);
        end
      end
    endcase
    ms = M_RUN;
    left = (kind == 1 || kind == 2) ? 24 : 36;
  endtask

  // One bus cycle: predict, compare read data, then advance the model.
  task automatic step(input logic [2:0] a, input bit w, input bit r,
                      input logic [7:0] d, input string req);
    logic [7:0] e;
    bit wa, wb, wx, rdd, go, rst, bad;
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    #1;
    e = 8'h00;
    if (r) begin
      case (a)
        3'd0: if (ms == M_DONE && qa.size() > 0) e = qa.pop_front();
        3'd1: if (ms == M_DONE && qb.size() > 0) e = qb.pop_front();
        3'd2: if (ms == M_DONE) e = 8'(mexp);
        3'd3: e = {1'b0, mcfg};
        3'd4: e = {3'b000, ms == M_DONE, mzro, movf, ms == M_ERR, ms == M_RUN};
        default: e = 8'h00;
      endcase
      chk(rdata == e, req, rdata, e);
    end
    wa = w && a == 0; wb = w && a == 1; wx = w && a == 2;
    rdd = r && !w && a < 3;
    go = w && a == 3 && d[7];
    rst = w && a == 4 && d[0];
    if (w && a == 3) mcfg = d[6:0];
    bad = 0;
    case (ms)
      M_IDLE, M_DONE: begin
        if (wa) begin ms = M_LOAD; fb = 0; na = 1; nb = 0; va = d; vb = 0; end
        else if (wb) begin ms = M_LOAD; fb = 1; na = 0; nb = 1; vb = d; va = 0; end
        else if (wx || go || (rdd && ms == M_IDLE)) bad = 1;
      end
      M_LOAD: begin
        if (!fb) begin
          if (wa) begin
            if (nb == 0 && na < 4) begin va |= longint'(d) << (8 * na); na++; end else bad = 1;
          end else if (wb) begin
            if (na == 2 || na == 4) begin
              vb |= longint'(d) << (8 * nb); nb++;
              if (nb == 2) begin_op(na == 4 ? 0 : 1);
            end else bad = 1;
          end else if (go) begin
            if (na == 4 && nb == 0) begin_op(mcfg[6] ? 4 : 3); else bad = 1;
          end else if (wx || rdd) bad = 1;
        end else begin
          if (wb) begin
            if (nb == 1 && na == 0) begin vb |= longint'(d) << 8; nb = 2; end else bad = 1;
          end else if (wa) begin
            if (nb == 2) begin
              va |= longint'(d) << (8 * na); na++;
              if (na == 2) begin_op(2);
            end else bad = 1;
          end else if (go || wx || rdd) bad = 1;
        end
      end
      M_RUN: begin
        if (wa || wb || wx || go) bad = 1;
        else if (left == 1) ms = M_DONE;
        else left--;
      end
      default: ;
    endcase
    if (bad) ms = M_ERR;
    if (rst) begin
      ms = M_IDLE; qa.delete(); qb.delete(); mexp = 0; movf = 0; mzro = 0;
    end
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0; addr = 3'd7;
  endtask

  task automatic wr_a32(input logic [31:0] v, input string req);
    for (int i = 0; i < 4; i++) step(3'd0, 1, 0, v[8*i +: 8], req);
  endtask

  // Poll STAT every cycle through the busy window and one cycle past it.
  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (ms == M_RUN && n < 64) begin step(3'd4, 0, 1, 8'h00, req); n++; end
    step(3'd4, 0, 1, 8'h00, req);
  endtask

  task automatic rd_n(input logic [2:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) step(a, 0, 1, 8'h00, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    step(3'd4, 0, 1, 8'h00, "R1");
    step(3'd3, 0, 1, 8'h00, "R1");
    step(3'd6, 0, 1, 8'h00, "R1");

    // R2 with R10 interleaving
    step(3'd0, 1, 0, 8'h78, "R2");
    step(3'd3, 1, 0, 8'h0A, "R10");
    step(3'd0, 1, 0, 8'h56, "R2");
    step(3'd4, 0, 1, 8'h00, "R10");
    step(3'd0, 1, 0, 8'h34, "R2");
    step(3'd5, 1, 0, 8'hFF, "R10");
    step(3'd0, 1, 0, 8'h12, "R2");
    step(3'd4, 1, 0, 8'h02, "R10");
    step(3'd1, 1, 0, 8'h34, "R2");
    step(3'd3, 0, 1, 8'h00, "R10");
    step(3'd1, 1, 0, 8'h12, "R2");
    // R8 reads while busy
    step(3'd0, 0, 1, 8'h00, "R8");
    step(3'd1, 0, 1, 8'h00, "R8");
    step(3'd2, 0, 1, 8'h00, "R8");
    wait_done("R7");
    rd_n(3'd0, 5, "R2");
    rd_n(3'd1, 2, "R2");

    // R3 then R13 (start from done)
    step(3'd0, 1, 0, 8'hEF, "R13");
    step(3'd0, 1, 0, 8'hBE, "R3");
    step(3'd1, 1, 0, 8'h23, "R3");
    step(3'd1, 1, 0, 8'h01, "R3");
    wait_done("R7");
    rd_n(3'd0, 1, "R3");
    // R13 new sequence from done with a partly read result
    step(3'd1, 1, 0, 8'hFF, "R13");
    step(3'd1, 1, 0, 8'hFF, "R4");
    step(3'd0, 1, 0, 8'hFF, "R4");
    step(3'd0, 1, 0, 8'hFF, "R4");
    wait_done("R7");
    rd_n(3'd0, 4, "R4");
    rd_n(3'd1, 1, "R4");

    // R5 shifts
    wr_a32(32'h8000_0001, "R5");
    step(3'd3, 1, 0, 8'h85, "R5");
    wait_done("R7");
    rd_n(3'd0, 4, "R5");
    step(3'd3, 0, 1, 8'h00, "R5");
    wr_a32(32'h8000_0000, "R5");
    step(3'd3, 1, 0, 8'hBF, "R5");
    wait_done("R7");
    rd_n(3'd0, 4, "R5");

    // R6 normalize
    wr_a32(32'h0001_2345, "R6");
    step(3'd3, 1, 0, 8'hC0, "R6");
    wait_done("R7");
    rd_n(3'd0, 4, "R6");
    rd_n(3'd2, 1, "R6");
    wr_a32(32'h0000_0000, "R6");
    step(3'd3, 1, 0, 8'hC0, "R6");
    wait_done("R7");
    rd_n(3'd0, 2, "R6");
    rd_n(3'd2, 1, "R6");

    // R9 divide by zero, then cleared by next start
    wr_a32(32'hCAFE_BABE, "R9");
    step(3'd1, 1, 0, 8'h00, "R9");
    step(3'd1, 1, 0, 8'h00, "R9");
    wait_done("R7");
    rd_n(3'd0, 4, "R9");
    rd_n(3'd1, 2, "R9");
    step(3'd0, 1, 0, 8'h10, "R9");
    step(3'd0, 1, 0, 8'h00, "R9");
    step(3'd1, 1, 0, 8'h00, "R9");
    step(3'd1, 1, 0, 8'h00, "R9");
    wait_done("R9");
    rd_n(3'd0, 2, "R9");
    step(3'd4, 0, 1, 8'h00, "R9");

    // R11 error from done, then locked
    step(3'd2, 1, 0, 8'h55, "R11");
    step(3'd4, 0, 1, 8'h00, "R11");
    step(3'd0, 1, 0, 8'h11, "R11");
    step(3'd0, 0, 1, 8'h00, "R11");
    step(3'd3, 1, 0, 8'h80, "R11");
    step(3'd4, 0, 1, 8'h00, "R11");
    // R12 restart
    step(3'd4, 1, 0, 8'h01, "R12");
    step(3'd4, 0, 1, 8'h00, "R12");
    // R11 bad order mid-load
    step(3'd0, 1, 0, 8'h01, "R11");
    step(3'd1, 1, 0, 8'h02, "R11");
    step(3'd4, 0, 1, 8'h00, "R11");
    step(3'd4, 1, 0, 8'h01, "R12");
    // R11 read in idle
    step(3'd1, 0, 1, 8'h00, "R11");
    step(3'd4, 0, 1, 8'h00, "R11");
    step(3'd4, 1, 0, 8'h01, "R12");
    // R11 write while busy aborts
    wr_a32(32'h0000_1000, "R11");
    step(3'd1, 1, 0, 8'h10, "R11");
    step(3'd1, 1, 0, 8'h00, "R11");
    rd_n(3'd4, 3, "R7");
    step(3'd0, 1, 0, 8'h00, "R11");
    rd_n(3'd4, 40, "R11");
    step(3'd4, 1, 0, 8'h01, "R12");
    // R12 restart while busy
    step(3'd1, 1, 0, 8'h03, "R12");
    step(3'd1, 1, 0, 8'h00, "R12");
    step(3'd0, 1, 0, 8'h07, "R12");
    step(3'd0, 1, 0, 8'h00, "R12");
    rd_n(3'd4, 5, "R12");
    step(3'd4, 1, 0, 8'h01, "R12");
    rd_n(3'd4, 30, "R12");
    rd_n(3'd0, 1, "R12");
    report();
  end

endmodule